// File: doc/BRIEF.md
# Pixel Stream Signature CRC Unit

The block condenses a video pixel stream into a 16-bit signature for display-path self-test. On each pixel clock that carries active video, it picks one colour channel of the 24-bit pixel and one bit position inside that 8-bit channel. It shifts that single bit into a serial CRC register built on the polynomial x^16 + x^12 + x^5 + 1. The data comes either from the live pixel bus or from an internal pattern generator. The internal generator is an 8-bit count that is copied onto all three channels.

Software sets up a run through a small indexed host port. It writes a control register, then starts accumulation by clearing the start bit after it was set. It later reads the signature as two bytes. The pixel input is a stream with a valid qualifier only. The block accepts one pixel on every clock where `pix_valid` is high and has no ready output, so the source never sees back-pressure and must not expect to be stalled. Cycles with `pix_valid` low stand for blanking.

Top module: `pix_sig_crc`

## Requirements
- R1: The control register sits at index 16'h0030 with these fields: [7:6] channel select, [5:3] bit position, [2] start, [1] source select. Bit [0] is reserved and always reads as 0. Reads of 16'h0031 return CRC bits 7..0, reads of 16'h0032 return CRC bits 15..8, and reads of any other index return 0.
- R2: A write to the control register that changes the start bit from 1 to 0 sets the CRC to 16'h0000 at that clock edge. That same edge shifts in no pixel.
- R3: A control write with start = 1, or with start = 0 while start already holds 0, leaves the CRC unchanged.
- R4: On each clock with `pix_valid` high, the selected bit d is shifted in: fb = crc[15]^d, then crc = {crc[14:0],0} ^ (fb ? 16'h1021 : 0).
- R5: Channel select 00 takes pixel bits [7:0] (blue), 01 takes [15:8] (green), and 10 takes [23:16] (red). Bit position k picks bit k of that byte.
- R6: With channel select 11, valid pixels leave the CRC unchanged.
- R7: Clocks with `pix_valid` low leave the CRC unchanged.
- R8: When source select is 1, the pixel used is {c,c,c}, where c is an 8-bit count. The count is 0 for the first valid pixel after an initialisation and goes up by 1 on each valid pixel. When source select is 0, `pix_data` is used.
- R9: Reset (`rst_n` low) clears neither the control fields nor the CRC. Both read back unchanged after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset (pattern count only) |
| host_idx | input | 16 | Register index for reads and writes |
| host_wdata | input | 8 | Write data |
| host_we | input | 1 | Write strobe, sampled on the rising clock edge |
| host_rdata | output | 8 | Combinational read data for `host_idx` |
| pix_valid | input | 1 | Active-video qualifier for `pix_data` |
| pix_data | input | 24 | Pixel: red [23:16], green [15:8], blue [7:0] |

## Verification
A wrong channel lane, a wrong bit index or a bad feedback tap does not stay hidden. The serial CRC spreads any single wrong bit across the register within a few shifts, so the byte reads that follow a short burst no longer match the model. An initialisation that fires on the wrong edge, or fails to fire, shows up as a nonzero read right after the restart write. A pattern count that drifts or is not cleared changes the signature from the first pattern pixel onward. A register that moves during blanking or with no channel selected shows up on the next read after those cycles.

// File: rtl/pix_crc_pkg.sv
package pix_crc_pkg;
  localparam int CHAN_W   = 8;
  localparam int NUM_CHAN = 3;
  localparam int PIX_W    = CHAN_W * NUM_CHAN;
  localparam int CRC_W    = 16;
  localparam int IDX_W    = 16;
  localparam int DAT_W    = 8;
  localparam int BPOS_W   = $clog2(CHAN_W);
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'h0000;
  localparam logic [IDX_W-1:0] IDX_CTRL   = 16'h0030;
  localparam logic [IDX_W-1:0] IDX_CRC_LO = 16'h0031;
  localparam logic [IDX_W-1:0] IDX_CRC_HI = 16'h0032;

  typedef enum logic [1:0] {
    CH_BLUE  = 2'b00,
    CH_GREEN = 2'b01,
    CH_RED   = 2'b10,
    CH_NONE  = 2'b11
  } chan_sel_e;

  typedef struct packed {
    chan_sel_e         chan;
    logic [BPOS_W-1:0] bitpos;
    logic              start;
    logic              src_pat;
  } ctrl_t;
endpackage

// File: rtl/crc_ctrl_regs.sv
module crc_ctrl_regs
  import pix_crc_pkg::*;
#(
  parameter int CW = CRC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [DAT_W-1:0] host_wdata,
  input  logic             host_we,
  input  logic [CW-1:0]    crc_val,
  output ctrl_t            ctrl,
  output logic             init_pulse,
  output logic [DAT_W-1:0] host_rdata
);
  localparam int CTRL_BITS = $bits(ctrl_t);

  ctrl_t ctrl_q;
  logic  wr_ctrl;
  ctrl_t wr_fields;

  assign wr_ctrl    = host_we && (host_idx == IDX_CTRL);
  assign wr_fields  = ctrl_t'(host_wdata[DAT_W-1 -: CTRL_BITS]);
  // restart only on a 1 -> 0 change of the start bit
  assign init_pulse = wr_ctrl && ctrl_q.start && !wr_fields.start;

  // control fields deliberately carry no reset
  always_ff @(posedge clk) begin
    if (wr_ctrl) ctrl_q <= wr_fields;
  end

  assign ctrl = ctrl_q;

  always_comb begin
    host_rdata = '0;
    if (host_idx == IDX_CTRL)
      host_rdata = {ctrl_q, {(DAT_W-CTRL_BITS){1'b0}}};
    else if (host_idx == IDX_CRC_LO)
      host_rdata = crc_val[DAT_W-1:0];
    else if (host_idx == IDX_CRC_HI)
      host_rdata = crc_val[CW-1 -: DAT_W];
  end

  // R1 reserved bit stays low on readback
  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_idx == IDX_CTRL) |-> (host_rdata[0] == 1'b0));

  // R3 a write that keeps start at 1 never restarts
  assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && host_wdata[2]) |-> !init_pulse);
endmodule

// File: rtl/crc_pattern_gen.sv
module crc_pattern_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         adv,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (init) count <= '0;
    else if (adv)  count <= count + 1'b1;
  end

  // R8 count steps by one per accepted pixel
  assert_pat_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !init) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/crc_bit_select.sv
module crc_bit_select
  import pix_crc_pkg::*;
#(
  parameter int CW = CHAN_W,
  parameter int NC = NUM_CHAN
) (
  input  logic [CW*NC-1:0]        pixel,
  input  chan_sel_e               chan,
  input  logic [$clog2(CW)-1:0]   bitpos,
  output logic                    bit_o,
  output logic                    bit_en
);
  logic [CW-1:0] lanes [NC];

  // lane 0 = blue (low byte), upward to red
  for (genvar g = 0; g < NC; g++) begin : g_lane
    assign lanes[g] = pixel[g*CW +: CW];
  end

  always_comb begin
    bit_en = (chan != CH_NONE);
    bit_o  = 1'b0;
    for (int i = 0; i < NC; i++)
      if (int'(chan) == i) bit_o = lanes[i][bitpos];
  end
endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine #(
  parameter int            W    = 16,
  parameter logic [W-1:0]  POLY = 16'h1021,
  parameter logic [W-1:0]  SEED = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic fb;
  assign fb = crc[W-1] ^ din;

  // signature register carries no reset
  always_ff @(posedge clk) begin
    if (init)          crc <= SEED;
    else if (shift_en) crc <= {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  // R2 initialisation lands on the seed
  assert_init_seed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (crc == SEED));
endmodule

// File: rtl/pix_sig_crc.sv
module pix_sig_crc
  import pix_crc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      host_idx,
  input  logic [7:0]       host_wdata,
  input  logic             host_we,
  output logic [7:0]       host_rdata,
  input  logic             pix_valid,
  input  logic [23:0]      pix_data
);
  ctrl_t             ctrl;
  logic              init_pulse;
  logic [CRC_W-1:0]  crc;
  logic [CHAN_W-1:0] pat_cnt;
  logic [PIX_W-1:0]  pix_src;
  logic              sel_bit, sel_en, shift_en;

  crc_ctrl_regs #(.CW(CRC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_idx(host_idx), .host_wdata(host_wdata),
    .host_we(host_we), .crc_val(crc), .ctrl(ctrl), .init_pulse(init_pulse),
    .host_rdata(host_rdata)
  );

  crc_pattern_gen #(.W(CHAN_W)) u_pat (
    .clk(clk), .rst_n(rst_n), .init(init_pulse), .adv(pix_valid),
    .count(pat_cnt)
  );

  assign pix_src = ctrl.src_pat ? {NUM_CHAN{pat_cnt}} : pix_data;

  crc_bit_select #(.CW(CHAN_W), .NC(NUM_CHAN)) u_sel (
    .pixel(pix_src), .chan(ctrl.chan), .bitpos(ctrl.bitpos),
    .bit_o(sel_bit), .bit_en(sel_en)
  );

  assign shift_en = pix_valid && sel_en && !init_pulse;

  crc_serial_engine #(.W(CRC_W), .POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
    .clk(clk), .rst_n(rst_n), .init(init_pulse), .shift_en(shift_en),
    .din(sel_bit), .crc(crc)
  );

  // R7 blanking leaves the signature alone
  assert_blank_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_valid && !init_pulse) |=> $stable(crc));

  // R6 no channel selected means no shift
  assert_none_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.chan == CH_NONE && !init_pulse) |=> $stable(crc));

  // R8 pattern count restarts with the signature
  assert_pat_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_pulse |=> (pat_cnt == '0));
endmodule

// File: tb/pix_sig_crc_tb.sv
module pix_sig_crc_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] host_idx = 0;
  logic [7:0]  host_wdata = 0;
  logic        host_we = 0;
  logic [7:0]  host_rdata;
  logic        pix_valid = 0;
  logic [23:0] pix_data = 0;

  int checks = 0, errors = 0;
  logic [15:0] m_crc;
  logic [7:0]  m_cnt;
  logic [1:0]  m_chan;
  logic [2:0]  m_bpos;
  logic        m_src;

  pix_sig_crc u_dut (.*);

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] idx, logic [7:0] d);
    @(negedge clk);
    host_idx = idx; host_wdata = d; host_we = 1;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic rd(logic [15:0] idx, output logic [7:0] d);
    @(negedge clk);
    host_idx = idx;
    #1 d = host_rdata;
  endtask

  function automatic logic [15:0] step(logic [15:0] c, logic d);
    logic fb = c[15] ^ d;
    return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0);
  endfunction

  function automatic logic [7:0] cval(logic [1:0] ch, logic [2:0] bp, logic st, logic sp);
    return {ch, bp, st, sp, 1'b0};
  endfunction

  task automatic restart(logic [1:0] ch, logic [2:0] bp, logic sp);
    wr(16'h0030, cval(ch, bp, 1'b1, sp));
    wr(16'h0030, cval(ch, bp, 1'b0, sp));
    m_chan = ch; m_bpos = bp; m_src = sp; m_crc = 0; m_cnt = 0;
  endtask

  task automatic feed(int n, int seed, bit gaps);
    for (int i = 0; i < n; i++) begin
      logic [23:0] p = 24'(i * 32'h9E3779 + seed * 32'h51ED27);
      logic [23:0] s;
      @(negedge clk);
      pix_data = p; pix_valid = 1;
      s = m_src ? {3{m_cnt}} : p;
      if (m_chan != 2'b11) m_crc = step(m_crc, s[m_chan*8 + m_bpos]);
      m_cnt++;
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk);
        pix_valid = 0; pix_data = ~p;
      end
    end
    @(negedge clk);
    pix_valid = 0;
  endtask

  task automatic chk_crc(string tag);
    logic [7:0] lo, hi;
    rd(16'h0031, lo);
    rd(16'h0032, hi);
    chk(tag, {hi, lo}, m_crc);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(16'h0030, 8'hFF);
    rd(16'h0030, d); chk("R1 ctrl readback reserved bit", {8'h0, d}, 16'h00FE);
    rd(16'h0044, d); chk("R1 unmapped index", {8'h0, d}, 16'h0000);
  endtask

  task automatic t_init;
    restart(2'b00, 3'd0, 1'b0);
    feed(5, 1, 0);
    restart(2'b00, 3'd0, 1'b0);
    chk_crc("R2 crc zero after start falling edge");
  endtask

  task automatic t_channels;
    restart(2'b00, 3'd0, 1'b0); feed(40, 2, 0); chk_crc("R4 R5 blue bit0");
    restart(2'b01, 3'd5, 1'b0); feed(40, 3, 0); chk_crc("R5 green bit5");
    restart(2'b10, 3'd7, 1'b0); feed(40, 4, 0); chk_crc("R5 red bit7");
    restart(2'b10, 3'd2, 1'b0); feed(33, 9, 0); chk_crc("R4 red bit2");
  endtask

  task automatic t_blank;
    restart(2'b01, 3'd3, 1'b0); feed(30, 5, 1); chk_crc("R7 gaps in valid");
  endtask

  task automatic t_none;
    restart(2'b00, 3'd1, 1'b0); feed(10, 6, 0);
    wr(16'h0030, cval(2'b11, 3'd1, 1'b0, 1'b0)); m_chan = 2'b11;
    feed(20, 7, 0); chk_crc("R6 channel none holds crc");
  endtask

  task automatic t_norestart;
    restart(2'b10, 3'd4, 1'b0); feed(12, 8, 0);
    wr(16'h0030, cval(2'b10, 3'd4, 1'b0, 1'b0));
    chk_crc("R3 write 0 over 0");
    wr(16'h0030, cval(2'b10, 3'd4, 1'b1, 1'b0));
    chk_crc("R3 write 1");
    wr(16'h0030, cval(2'b10, 3'd4, 1'b1, 1'b0));
    chk_crc("R3 write 1 over 1");
  endtask

  task automatic t_pattern;
    restart(2'b00, 3'd0, 1'b1); feed(300, 10, 0); chk_crc("R8 pattern blue bit0");
    restart(2'b01, 3'd6, 1'b1); feed(200, 11, 1); chk_crc("R8 pattern green bit6 gaps");
    restart(2'b10, 3'd7, 1'b1); feed(260, 12, 0); chk_crc("R8 pattern red bit7 wrap");
  endtask

  task automatic t_reset_keep;
    logic [7:0] d;
    restart(2'b01, 3'd2, 1'b0); feed(25, 13, 0);
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(16'h0030, d); chk("R9 ctrl kept over reset", {8'h0, d}, {8'h0, cval(2'b01, 3'd2, 1'b0, 1'b0)});
    chk_crc("R9 crc kept over reset");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_regs();
    t_init();
    t_channels();
    t_blank();
    t_none();
    t_norestart();
    t_pattern();
    t_reset_keep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule